// File: doc/BRIEF.md
# Dual-Rail Enable Sequencer

This block decides when each of two switching-regulator channels may begin its soft-start ramp. Each channel has its own enable input, and each enable is a three-level code: low, high or floating. Low and floating alone never start anything. High starts the channel directly. A floating enable paired with a high one sets up an ordered start-up: the high channel leads, and the floating channel follows once the leader reports that it is in regulation.

The block also drives the enable of a 5 V auxiliary supply. That enable stays off until at least one of the two channel enables, or a separate auxiliary-regulator enable, is high. This keeps shutdown current low. No channel may start until the supply's power-on-reset-good flag is set.

For each running channel, a counter measures the soft-start interval and then a further power-good delay. Both lengths are parameters counted in clock cycles. The power-good output of a channel rises when the whole interval has elapsed and the channel reports that it is in regulation. If a channel's start condition goes away, its soft-start enable and power-good fall in that same cycle, and its counter starts over.

Top module: `rail_start_sequencer`

## Requirements
- R1: `auxSupplyEn` is high exactly when `en1Code` or `en2Code` equals 2'b01 (high), or when `auxLdoEn` is high. The float code 2'b10 does not count.
- R2: While `porOk` is low, both bits of `softStartEn` are low, whatever the enables are.
- R3: Any pair of enable codes built only from low (2'b00) and float (2'b10) keeps both `softStartEn` bits low.
- R4: With `en1Code`=high and `en2Code`=low, only `softStartEn[0]` is high. With `en1Code`=low and `en2Code`=high, only `softStartEn[1]` is high. Bit 0 is the channel of `en1Code`, and bit 1 is the channel of `en2Code`.
- R5: With both codes high and `porOk` high, both `softStartEn` bits are high in the same cycle.
- R6: With `en1Code`=float and `en2Code`=high, `softStartEn[1]` is high, and `softStartEn[0]` rises only while `inReg[1]` is high. The mirror case (`en1Code`=high, `en2Code`=float) makes `softStartEn[1]` wait for `inReg[0]`.
- R7: In an ordered start, once the following channel has started, it stays enabled even if the leader's `inReg` bit later falls, for as long as the codes and `porOk` stay unchanged.
- R8: `powerGood[i]` rises on the (SOFT_CYCLES+PGOOD_DELAY_CYCLES)-th rising clock edge at which `softStartEn[i]` has been continuously high, not one edge earlier. It is only high while `inReg[i]` is high.
- R9: When a channel's start condition is removed, `softStartEn[i]` and `powerGood[i]` fall in the same cycle. A later restart again takes the full delay of R8.
- R10: The enable code 2'b11 behaves exactly like low (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en1Code | input | 2 | Channel-1 enable level: 00 low, 01 high, 10 float, 11 low |
| en2Code | input | 2 | Channel-2 enable level, same coding |
| auxLdoEn | input | 1 | Enable of the auxiliary linear regulator |
| porOk | input | 1 | 5 V rail is above its power-on-reset threshold |
| inReg | input | 2 | Per-channel in-regulation flag |
| auxSupplyEn | output | 1 | Enable of the 5 V auxiliary supply |
| softStartEn | output | 2 | Per-channel soft-start enable |
| powerGood | output | 2 | Per-channel delayed power-good |

## Verification
The assertions check on every cycle the following properties:
- No channel runs without the power-on flag.
- A following channel only ever starts while its leader reports regulation.
- A running channel always has the auxiliary supply on.
- Power-good rises only after the channel has been running.
- The counter never passes its limit, and it restarts after a drop.

Only the bench scenarios can show the following behaviours:
- The full decode of all sixteen code pairs.
- The exact cycle on which power-good rises.
- That a started follower holds after its leader drops.
- That a removed enable gives a fresh full delay on restart.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_HIGH  = 2'b01,
    LVL_FLOAT = 2'b10,
    LVL_RSVD  = 2'b11
  } enLevel_e;

  typedef struct packed {
    logic [NCH-1:0] run;
    logic [NCH-1:0] restart;
  } seqStrobe_t;

  function automatic logic isHigh(input logic [1:0] code);
    return code == LVL_HIGH;
  endfunction

  function automatic logic isFloat(input logic [1:0] code);
    return code == LVL_FLOAT;
  endfunction

endpackage

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       en1Code,
  input  logic [1:0]       en2Code,
  input  logic             auxLdoEn,
  input  logic             porOk,
  input  logic [NCH-1:0]   inReg,
  output logic             auxSupplyEn,
  output seqStrobe_t       strobe
);

  logic hi0, hi1, fl0, fl1;
  logic [NCH-1:0] run;
  logic [NCH-1:0] followMode;
  logic [NCH-1:0] armed;

  always_comb begin
    hi0 = isHigh(en1Code);
    hi1 = isHigh(en2Code);
    fl0 = isFloat(en1Code);
    fl1 = isFloat(en2Code);
    auxSupplyEn = hi0 | hi1 | auxLdoEn;
  end

  always_comb begin
    run        = '0;
    followMode = '0;
    if (porOk) begin
      if (hi0 && hi1) begin
        run = '1;
      end else if (hi0 && fl1) begin
        run[0]        = 1'b1;
        followMode[1] = 1'b1;
        run[1]        = armed[1] | inReg[0];
      end else if (fl0 && hi1) begin
        run[1]        = 1'b1;
        followMode[0] = 1'b1;
        run[0]        = armed[0] | inReg[1];
      end else begin
        run[0] = hi0;
        run[1] = hi1;
      end
    end
  end

  // A follower stays latched on while the ordered mode lasts.
  always_ff @(posedge clk) begin
    if (!rstN) armed <= '0;
    else       armed <= followMode & run;
  end

  assign strobe.run     = run;
  assign strobe.restart = ~run;

  p_no_start_without_por_r2: assert property (@(posedge clk) disable iff (!rstN)
    !porOk |-> (run == '0));

  p_aux_on_when_running_r1: assert property (@(posedge clk) disable iff (!rstN)
    (run != '0) |-> auxSupplyEn);

  p_follow0_waits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (followMode[0] && $rose(run[0])) |-> inReg[1]);

  p_follow1_waits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (followMode[1] && $rose(run[1])) |-> inReg[0]);

  p_rsvd_is_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (en1Code == LVL_RSVD && !fl1) |-> !run[0]);

endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer
  import rail_seq_pkg::*;
#(
  parameter int SOFT_CYCLES        = 6000,
  parameter int PGOOD_DELAY_CYCLES = 5000
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strobe,
  input  logic [NCH-1:0] inReg,
  output logic [NCH-1:0] powerGood
);

  localparam int TOTAL = SOFT_CYCLES + PGOOD_DELAY_CYCLES;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TOTAL);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
      if (!rstN || strobe.restart[ch]) count <= '0;
      else if (count < LIMIT)          count <= count + 1'b1;
    end

    assign powerGood[ch] = strobe.run[ch] & inReg[ch] & (count >= LIMIT);

    p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rstN)
      count <= LIMIT);

    p_pgood_after_run_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(powerGood[ch]) |-> $past(strobe.run[ch]));

    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.run[ch] |=> (count == '0));
  end

endmodule

// File: rtl/rail_start_sequencer.sv
module rail_start_sequencer #(
  parameter int SOFT_CYCLES        = 6000,
  parameter int PGOOD_DELAY_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] en1Code,
  input  logic [1:0] en2Code,
  input  logic       auxLdoEn,
  input  logic       porOk,
  input  logic [1:0] inReg,
  output logic       auxSupplyEn,
  output logic [1:0] softStartEn,
  output logic [1:0] powerGood
);

  rail_seq_pkg::seqStrobe_t strobe;

  rail_seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .en1Code    (en1Code),
    .en2Code    (en2Code),
    .auxLdoEn   (auxLdoEn),
    .porOk      (porOk),
    .inReg      (inReg),
    .auxSupplyEn(auxSupplyEn),
    .strobe     (strobe)
  );

  rail_seq_timer #(
    .SOFT_CYCLES       (SOFT_CYCLES),
    .PGOOD_DELAY_CYCLES(PGOOD_DELAY_CYCLES)
  ) i_timer (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inReg    (inReg),
    .powerGood(powerGood)
  );

  assign softStartEn = strobe.run;

  p_pgood_implies_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((powerGood & ~softStartEn) == 2'b00));

endmodule

// File: tb/test_rail_start_sequencer.sv
module test_rail_start_sequencer;

  localparam int PERIOD = 10;
  localparam int SOFT   = 5;
  localparam int PGD    = 7;
  localparam int TOTAL  = SOFT + PGD;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] en1Code, en2Code, inReg;
  logic auxLdoEn, porOk;
  logic auxSupplyEn;
  logic [1:0] softStartEn, powerGood;

  int nTests = 0;
  int nFail  = 0;

  always #(PERIOD/2) clk = ~clk;

  rail_start_sequencer #(.SOFT_CYCLES(SOFT), .PGOOD_DELAY_CYCLES(PGD)) i_rail_start_sequencer (
    .clk(clk), .rstN(rstN), .en1Code(en1Code), .en2Code(en2Code),
    .auxLdoEn(auxLdoEn), .porOk(porOk), .inReg(inReg),
    .auxSupplyEn(auxSupplyEn), .softStartEn(softStartEn), .powerGood(powerGood)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expRun(input logic [1:0] c1, input logic [1:0] c2,
                                        input logic por, input logic [1:0] reg_);
    logic h1, h2, f1, f2;
    h1 = (c1 == 2'b01); h2 = (c2 == 2'b01);
    f1 = (c1 == 2'b10); f2 = (c2 == 2'b10);
    if (!por)          return 2'b00;
    if (h1 && h2)      return 2'b11;
    if (h1 && f2)      return {reg_[0], 1'b1};
    if (f1 && h2)      return {1'b1, reg_[1]};
    return {h2, h1};
  endfunction

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 20000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; en1Code = 2'b00; en2Code = 2'b00; inReg = 2'b00;
    auxLdoEn = 1'b0; porOk = 1'b0;
    waitEdges(3);
    check("R2 reset softStartEn", softStartEn, 0);
    check("R8 reset powerGood", powerGood, 0);
    check("R1 reset auxSupplyEn", auxSupplyEn, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Exhaustive decode sweep: R1 R2 R3 R4 R5 R6 R10
    for (int c1 = 0; c1 < 4; c1++)
      for (int c2 = 0; c2 < 4; c2++)
        for (int p = 0; p < 2; p++)
          for (int a = 0; a < 2; a++)
            for (int r = 0; r < 4; r++) begin
              porOk = 1'b0; inReg = 2'b00;
              @(negedge clk);
              en1Code = 2'(c1); en2Code = 2'(c2); porOk = p[0];
              auxLdoEn = a[0]; inReg = 2'(r);
              #2;
              check("R1 auxSupplyEn decode", auxSupplyEn,
                    int'((c1 == 1) || (c2 == 1) || (a == 1)));
              check("R2/R3/R4/R5/R6/R10 softStartEn decode", softStartEn,
                    expRun(2'(c1), 2'(c2), p[0], 2'(r)));
              @(negedge clk);
            end

    // R5 and R8: both high, exact power-good edge
    porOk = 1'b0; auxLdoEn = 1'b0; inReg = 2'b11;
    @(negedge clk);
    en1Code = 2'b01; en2Code = 2'b01; porOk = 1'b1;
    #1;
    check("R5 simultaneous start", softStartEn, 3);
    waitEdges(TOTAL - 1);
    check("R8 powerGood one edge early", powerGood, 0);
    waitEdges(1);
    check("R8 powerGood at full delay", powerGood, 3);
    inReg = 2'b01;
    #1;
    check("R8 powerGood gated by inReg", powerGood, 1);
    inReg = 2'b11;

    // R9: drop channel 2, restart needs full delay
    @(negedge clk);
    en2Code = 2'b00;
    #1;
    check("R9 drop softStartEn same cycle", softStartEn, 1);
    check("R9 drop powerGood same cycle", powerGood, 1);
    @(negedge clk);
    en2Code = 2'b01;
    waitEdges(TOTAL - 1);
    check("R9 restart not early", powerGood[1], 0);
    waitEdges(1);
    check("R9 restart full delay", powerGood[1], 1);

    // R6 and R7: float/high ordered start
    porOk = 1'b0; inReg = 2'b00;
    @(negedge clk);
    en1Code = 2'b10; en2Code = 2'b01; porOk = 1'b1;
    waitEdges(4);
    check("R6 follower waits", softStartEn, 2);
    @(negedge clk);
    inReg[1] = 1'b1;
    #1;
    check("R6 follower starts on leader inReg", softStartEn, 3);
    waitEdges(1);
    @(negedge clk);
    inReg[1] = 1'b0;
    waitEdges(3);
    check("R7 follower holds after leader drops", softStartEn, 3);

    // R6 and R7 mirror
    porOk = 1'b0; inReg = 2'b00;
    @(negedge clk);
    en1Code = 2'b01; en2Code = 2'b10; porOk = 1'b1;
    waitEdges(4);
    check("R6 mirror follower waits", softStartEn, 1);
    @(negedge clk);
    inReg[0] = 1'b1;
    waitEdges(1);
    @(negedge clk);
    inReg[0] = 1'b0;
    waitEdges(3);
    check("R7 mirror follower holds", softStartEn, 3);
    inReg[1] = 1'b1;
    waitEdges(TOTAL);
    check("R8 follower powerGood after its own delay", powerGood, 2);

    // R2: losing porOk stops everything at once
    @(negedge clk);
    porOk = 1'b0;
    #1;
    check("R2 por loss stops channels", softStartEn, 0);
    check("R9 por loss drops powerGood", powerGood, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule